// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Register

This block keeps the status byte of a serial flash device and judges which write operations may go ahead. A command decoder in front of it pulses a strobe with each received opcode. A shift-out path reads the status byte. The array controller asks it two things: whether a given byte address is shielded, and whether a whole-array erase may start. The controller reports back when a program, an erase or an auto-increment programming run has finished.

Status-register writes are guarded twice. First, the write opcode must directly follow an arming opcode. Second, a lock bit combines with the write-protect pin level. The pin level is taken in the cycle in which chip enable rises at the end of the status-write command. A two-bit protect code selects a fixed range at the top of the array. Reset leaves the whole array shielded.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte reads 0x0C (both protect bits 1, all other bits 0), `addr_prot` is 1 for address 0x00000, and `chip_erase_ok` is 0.
- R2: The status byte is {BPL, AAI, 0, 0, BP1, BP0, WEL, BUSY} from bit 7 down to bit 0. BUSY follows the `op_busy` input.
- R3: Protect code {BP1,BP0}=00 shields no address. Code 01 shields 0x70000–0x7FFFF, code 10 shields 0x60000–0x7FFFF, and code 11 shields every address. `addr_prot` is combinational on `chk_addr`.
- R4: `chip_erase_ok` is 1 exactly when BP1 and BP0 are both 0.
- R5: Opcode 0x01 writes the status byte only when the previous strobed opcode was 0x50 or 0x06. The new value is taken from `sr_wdata` (bit 7 to BPL, bits 3:2 to BP1:BP0) when `cs_rise` pulses. An unarmed 0x01, or an arm followed by any other opcode, leaves the byte unchanged.
- R6: A status write is ignored when `wp_lvl` is 0 and BPL is 1. When `wp_lvl` is 1, BPL, BP1 and BP0 can all be changed, including clearing BPL.
- R7: With `wp_lvl` 0 and BPL 0, one status write may set BPL and change BP1/BP0 together. The pin level used is the one present in the `cs_rise` cycle.
- R8: Opcode 0x06 sets WEL. WEL is cleared by opcode 0x04, by an accepted status write, by `prog_done` and by `erase_done`.
- R9: Opcode 0xAF sets AAI when WEL is 1 and has no effect when WEL is 0. Opcode 0x04 clears AAI. `aai_end` clears both AAI and WEL.
- R10: When opcode 0x06 is strobed in the same cycle as `prog_done` or `erase_done`, WEL ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: an opcode was decoded |
| cmd_op | input | 8 | Decoded opcode |
| sr_wdata | input | 8 | Status data byte for a status write |
| wp_lvl | input | 1 | Write-protect pin level (1 = lock disabled) |
| cs_rise | input | 1 | One-cycle strobe: chip enable went high |
| prog_done | input | 1 | Byte program finished |
| erase_done | input | 1 | Sector or chip erase finished |
| aai_end | input | 1 | Auto-increment programming reached the top address |
| op_busy | input | 1 | Internal write operation in progress |
| chk_addr | input | 19 | Byte address to test against the protect code |
| status_byte | output | 8 | Status register contents |
| addr_prot | output | 1 | `chk_addr` lies in the shielded range |
| chip_erase_ok | output | 1 | Whole-array erase permitted |
| wel | output | 1 | Write-enable latch |
| aai | output | 1 | Auto-increment programming mode |
| busy | output | 1 | Busy bit |

## Verification
The write-enable latch has a setting source (the 0x06 strobe) and clearing sources (the completion pulses). These can arrive in the same clock. The bench raises `cmd_valid` with 0x06 together with `prog_done` in one cycle and expects WEL to read 1 afterwards. A second collision is the pin changing level inside a status-write command. The bench holds `wp_lvl` low through the 0x01 strobe and raises it only in the `cs_rise` cycle. It then expects a locked register to be rewritten, which shows that the level is taken at the close of the command.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_ARMSR = 8'h50;
    localparam logic [7:0] OP_AAI   = 8'hAF;

    typedef struct packed {
        logic       bpl;
        logic       aai;
        logic [1:0] bp;
        logic       wel;
    } sr_state_t;

    typedef struct packed {
        logic armed;
        logic pend;
    } arm_state_t;

    function automatic logic is_arm_op(input logic [7:0] op);
        return (op == OP_ARMSR) || (op == OP_WREN);
    endfunction
endpackage

// File: rtl/fsr_prot_map.sv
module fsr_prot_map #(
    parameter int ADDR_W = 19
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int EIGHTH_W  = 3;
    localparam int QUARTER_W = 2;

    logic top_eighth, top_quarter;

    always_comb begin
        top_eighth  = &addr[ADDR_W-1 -: EIGHTH_W];
        top_quarter = &addr[ADDR_W-1 -: QUARTER_W];
        unique case (bp)
            2'b00:   prot = 1'b0;
            2'b01:   prot = top_eighth;
            2'b10:   prot = top_quarter;
            default: prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/fsr_arm_seq.sv
module fsr_arm_seq
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_op,
    input  logic       cs_rise,
    output logic       commit
);
    arm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_rise) st_d.pend = 1'b0;
        if (cmd_valid) begin
            st_d.armed = is_arm_op(cmd_op);
            st_d.pend  = (cmd_op == OP_WRSR) && st_q.armed;
        end
        commit = cs_rise && st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !is_arm_op(cmd_op)) |=> !st_q.armed);

    // R5
    pend_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRSR && !st_q.armed) |=> !st_q.pend);
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [7:0]        sr_wdata,
    input  logic              wp_lvl,
    input  logic              cs_rise,
    input  logic              prog_done,
    input  logic              erase_done,
    input  logic              aai_end,
    input  logic              op_busy,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        status_byte,
    output logic              addr_prot,
    output logic              chip_erase_ok,
    output logic              wel,
    output logic              aai,
    output logic              busy
);
    localparam sr_state_t SR_RESET = '{bpl: 1'b0, aai: 1'b0, bp: 2'b11, wel: 1'b0};

    sr_state_t sr_d, sr_q;
    logic      commit;
    logic      locked;
    logic      unused_wdata;

    assign unused_wdata = &{1'b0, sr_wdata[6:4], sr_wdata[1:0]};

    fsr_arm_seq u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cs_rise   (cs_rise),
        .commit    (commit)
    );

    fsr_prot_map #(.ADDR_W(ADDR_W)) u_map (
        .bp   (sr_q.bp),
        .addr (chk_addr),
        .prot (addr_prot)
    );

    always_comb begin
        sr_d   = sr_q;
        locked = !wp_lvl && sr_q.bpl;
        if (prog_done || erase_done) sr_d.wel = 1'b0;
        if (aai_end) begin
            sr_d.wel = 1'b0;
            sr_d.aai = 1'b0;
        end
        if (commit && !locked) begin
            sr_d.bpl = sr_wdata[7];
            sr_d.bp  = sr_wdata[3:2];
            sr_d.wel = 1'b0;
        end
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_WREN: sr_d.wel = 1'b1;
                OP_WRDI: begin
                    sr_d.wel = 1'b0;
                    sr_d.aai = 1'b0;
                end
                OP_AAI:  if (sr_q.wel) sr_d.aai = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= SR_RESET;
        else        sr_q <= sr_d;
    end

    always_comb begin
        busy          = op_busy;
        wel           = sr_q.wel;
        aai           = sr_q.aai;
        chip_erase_ok = (sr_q.bp == 2'b00);
        status_byte   = {sr_q.bpl, sr_q.aai, 2'b00, sr_q.bp, sr_q.wel, op_busy};
    end

    // R6
    bpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_lvl && sr_q.bpl) |=> sr_q.bpl);

    // R8
    wren_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WREN) |=> sr_q.wel);

    // R9
    wrdi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRDI) |=> (!sr_q.wel && !sr_q.aai));

    // R3
    open_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_ok |-> !addr_prot);

    // R9
    aai_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_q.aai) |-> $past(sr_q.wel));
endmodule

// File: tb/tb_flash_sr_guard.sv
module tb_flash_sr_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [7:0]  sr_wdata = 8'h00;
    logic        wp_lvl = 1'b1;
    logic        cs_rise = 1'b0;
    logic        prog_done = 1'b0;
    logic        erase_done = 1'b0;
    logic        aai_end = 1'b0;
    logic        op_busy = 1'b0;
    logic [18:0] chk_addr = '0;
    logic [7:0]  status_byte;
    logic        addr_prot, chip_erase_ok, wel, aai, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_sr_guard dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .sr_wdata(sr_wdata), .wp_lvl(wp_lvl), .cs_rise(cs_rise),
        .prog_done(prog_done), .erase_done(erase_done), .aai_end(aai_end),
        .op_busy(op_busy), .chk_addr(chk_addr), .status_byte(status_byte),
        .addr_prot(addr_prot), .chip_erase_ok(chip_erase_ok), .wel(wel),
        .aai(aai), .busy(busy)
    );

    // {bp[1:0], addr[18:0], expected protected}
    localparam int NV = 10;
    localparam logic [21:0] VEC [NV] = '{
        {2'b00, 19'h7FFFF, 1'b0}, {2'b01, 19'h6FFFF, 1'b0},
        {2'b01, 19'h70000, 1'b1}, {2'b01, 19'h7FFFF, 1'b1},
        {2'b10, 19'h5FFFF, 1'b0}, {2'b10, 19'h60000, 1'b1},
        {2'b11, 19'h00000, 1'b1}, {2'b11, 19'h3ABCD, 1'b1},
        {2'b00, 19'h00000, 1'b0}, {2'b10, 19'h7FFFF, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_sr(input string req, input logic [7:0] exp);
        chk(status_byte == exp, req, status_byte, exp);
    endtask

    task automatic step(input bit v, input logic [7:0] op, input bit csr,
                        input bit pd, input bit ed, input bit ae);
        cmd_valid = v; cmd_op = op; cs_rise = csr;
        prog_done = pd; erase_done = ed; aai_end = ae;
        @(negedge clk);
        cmd_valid = 0; cs_rise = 0; prog_done = 0; erase_done = 0; aai_end = 0;
    endtask

    task automatic cmd(input logic [7:0] op);
        step(1, op, 0, 0, 0, 0);
        step(0, 8'h00, 1, 0, 0, 0);
    endtask

    task automatic sr_write(input logic [7:0] data);
        step(1, 8'h01, 0, 0, 0, 0);
        sr_wdata = data;
        step(0, 8'h00, 1, 0, 0, 0);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_sr("R1 reset status", 8'h0C);
        chk(addr_prot == 1'b1, "R1 reset prot", addr_prot, 1);
        chk(chip_erase_ok == 1'b0, "R1 reset ce_ok", chip_erase_ok, 0);

        // R3 R4 R5 table walk: arm with 0x06, write bp, probe address
        for (int i = 0; i < NV; i++) begin
            logic [1:0] bpv;
            bpv = VEC[i][21:20];
            cmd(8'h06);
            sr_write({4'b0, bpv, 2'b00});
            chk_addr = VEC[i][19:1];
            #1;
            chk_sr("R5 armed write", {4'b0, bpv, 2'b00});
            chk(addr_prot == VEC[i][0], "R3 prot map", addr_prot, VEC[i][0]);
            chk(chip_erase_ok == (bpv == 2'b00), "R4 ce_ok", chip_erase_ok, bpv == 2'b00);
        end

        // R5 unarmed write ignored (bp currently 10)
        sr_write(8'h00);
        chk_sr("R5 unarmed", 8'h08);
        // R5 arm then another opcode then write: ignored
        cmd(8'h50); cmd(8'h05); sr_write(8'h00);
        chk_sr("R5 arm discarded", 8'h08);
        // R5 arm with 0x50 works
        cmd(8'h50); sr_write(8'h00);
        chk_sr("R5 arm 0x50", 8'h00);

        // R7 pin low, BPL 0: set BPL and BP together
        wp_lvl = 0;
        cmd(8'h50); sr_write(8'h84);
        chk_sr("R7 lock and bp", 8'h84);
        // R6 locked: ignored
        cmd(8'h50); sr_write(8'h00);
        chk_sr("R6 locked ignored", 8'h84);
        // R7 pin level taken at cs_rise
        cmd(8'h50);
        step(1, 8'h01, 0, 0, 0, 0);
        sr_wdata = 8'h00; wp_lvl = 1;
        step(0, 8'h00, 1, 0, 0, 0);
        chk_sr("R7 pin sampled at cs_rise / R6 unlock", 8'h00);

        // R8 WEL sources
        cmd(8'h06); chk(wel == 1, "R8 wren", wel, 1);
        chk_sr("R2 wel bit", 8'h02);
        cmd(8'h04); chk(wel == 0, "R8 wrdi", wel, 0);
        cmd(8'h06); step(0, 8'h00, 0, 1, 0, 0);
        chk(wel == 0, "R8 prog_done", wel, 0);
        cmd(8'h06); step(0, 8'h00, 0, 0, 1, 0);
        chk(wel == 0, "R8 erase_done", wel, 0);
        cmd(8'h06); cmd(8'h50); sr_write(8'h00);
        chk(wel == 0, "R8 status write clears", wel, 0);

        // R9 AAI
        cmd(8'hAF); chk(aai == 0, "R9 aai without wel", aai, 0);
        cmd(8'h06); cmd(8'hAF);
        chk_sr("R9 aai set", 8'h42);
        cmd(8'h04); chk_sr("R9 wrdi clears aai", 8'h00);
        cmd(8'h06); cmd(8'hAF); step(0, 8'h00, 0, 0, 0, 1);
        chk_sr("R9 aai_end", 8'h00);

        // R10 same-cycle set and clear
        step(1, 8'h06, 0, 1, 0, 0);
        chk(wel == 1, "R10 wren vs prog_done", wel, 1);
        step(1, 8'h06, 0, 0, 1, 0);
        chk(wel == 1, "R10 wren vs erase_done", wel, 1);

        // R2 busy bit
        op_busy = 1; #1;
        chk_sr("R2 busy bit", 8'h03);
        chk(busy == 1, "R2 busy port", busy, 1);
        op_busy = 0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule